// File: doc/BRIEF.md
# PC Card Memory Decode and Byte Steering

This block is the control logic inside a PC Card memory card whose storage is a row of 512K-byte flash parts, grouped in pairs. One part of each pair serves data bits 7..0 and the other serves data bits 15..8. The block takes the host's card enables, register select, output and write strobes, address and the write-protect switch. From them it drives one chip enable per flash part, a chip enable for the 512-byte attribute memory, shared read and write strobes, and the enable and direction controls for three data transceiver paths:

- low lane to the low bus,
- high lane to the high bus,
- a crossover that brings the high bus down to data bits 7..0.

All outputs are registered. Their values reflect the host inputs sampled at the previous clock edge. While a write pulse is in progress, the decoded selection and the device addresses stay frozen at their values from the cycle the pulse began. The parts being written therefore see one steady target for the whole pulse.

Top module: `pcm_card_ctrl`

## Requirements
- R1: While reset is asserted, every chip enable and both shared strobes are high (inactive), all three transceiver enables are high (off), the toward-host direction bit is 0 and the protect status is 0.
- R2: When both card enables are high at the sampled edge and no write pulse is being held, no flash chip enable and no attribute chip enable is low one cycle later.
- R3: A word access (both card enables low, register select high) to pair k = address bits 23..20, with k below SEG_COUNT, drives low the low-byte and high-byte enables of pair k only. It turns on the low and high lanes. The device address output carries host address bits 19..1.
- R4: A byte access through card enable 1 alone selects the low part of the pair and the low lane when address bit 0 is 0. When address bit 0 is 1, it selects the high part and the crossover path.
- R5: An access through card enable 2 alone selects only the high part of the pair and the high lane.
- R6: A flash access whose pair number is SEG_COUNT or above enables no flash part and no transceiver path.
- R7: With register select low, only the attribute chip enable is driven low, never a flash enable. Only the low lane may be used. The attribute address output carries host address bits 9..1.
- R8: In attribute space, an odd byte access (card enable 1 alone with address bit 0 = 1, or card enable 2 alone) enables neither the attribute memory nor any transceiver path.
- R9: When the protect switch input is 1, the shared write strobe stays high. The protect status output follows the switch one cycle later.
- R10: Each transceiver path is on only when exactly one of the read and write strobes is low. The direction bit is 1 (toward host) only when the read strobe is low, the write strobe is high and some path is chosen. With both strobes low, all paths are off.
- R11: While the write strobe is sampled low on two successive edges, the chip enables, device address, attribute address and chosen paths keep the values taken on the first of those edges.
- R12: The shared read strobe output equals the sampled read strobe one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | HADDR_W | Host address |
| ce1_n | input | 1 | Card enable for the even/low byte, active low |
| ce2_n | input | 1 | Card enable for the odd/high byte, active low |
| reg_n | input | 1 | Attribute space select, active low |
| oe_n | input | 1 | Host read strobe, active low |
| we_n | input | 1 | Host write strobe, active low |
| wp_sw | input | 1 | Protect switch, 1 = protected |
| flash_ce_lo_n | output | SEG_COUNT | Chip enables of the low-byte parts |
| flash_ce_hi_n | output | SEG_COUNT | Chip enables of the high-byte parts |
| attr_ce_n | output | 1 | Attribute memory chip enable |
| dev_addr | output | DEV_AW | Address inside a flash part |
| attr_addr | output | ATTR_AW | Address inside the attribute memory |
| mem_oe_n | output | 1 | Shared read strobe to the memories |
| mem_we_n | output | 1 | Shared write strobe, blocked by protect |
| xcv_lo_en_n | output | 1 | Low lane transceiver enable |
| xcv_hi_en_n | output | 1 | High lane transceiver enable |
| xcv_swap_en_n | output | 1 | Crossover transceiver enable |
| xcv_to_host | output | 1 | Transceiver direction, 1 = card drives host |
| wp_stat | output | 1 | Protect status, active high |

## Verification
The assertions assume a host that holds each strobe level for at least one clock. They also assume that the only register-held state that matters across edges is the write-pulse freeze, so every property is phrased one edge after the inputs that cause it. The stimulus changes inputs only between edges and holds each pattern for whole cycles. It then deliberately breaks host etiquette in a few places: the address moves in the middle of a write pulse, and the read and write strobes are driven low together, so that the freeze and the contention guard are exercised. A pseudo-random phase mixes all input patterns, including pair numbers above the installed count. A behavioural model judges every cycle.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

    // Which parts and data paths an access uses.
    typedef struct packed {
        logic lo_dev;    // low-byte flash part of the pair
        logic hi_dev;    // high-byte flash part of the pair
        logic attr;      // attribute memory
        logic lane_lo;   // low bus <-> data 7..0
        logic lane_hi;   // high bus <-> data 15..8
        logic lane_swap; // high bus <-> data 7..0
    } route_t;

    localparam route_t ROUTE_NONE = '0;

endpackage

// File: rtl/pcm_seg_decode.sv
module pcm_seg_decode #(
    parameter int SEG_COUNT = 10,
    parameter int IDX_W     = 4
) (
    input  logic [IDX_W-1:0]     seg_idx,
    input  logic                 lo_req,
    input  logic                 hi_req,
    output logic                 in_range,
    output logic [SEG_COUNT-1:0] ce_lo_n,
    output logic [SEG_COUNT-1:0] ce_hi_n
);

    localparam int IDX_SPAN = 1 << IDX_W;

    initial begin
        if (SEG_COUNT > IDX_SPAN || SEG_COUNT < 1)
            $error("pcm_seg_decode: SEG_COUNT does not fit the index width");
    end

    always_comb begin
        in_range = (int'(seg_idx) < SEG_COUNT);
    end

    for (genvar g = 0; g < SEG_COUNT; g++) begin : g_pair
        logic hit;
        always_comb begin
            hit        = (seg_idx == IDX_W'(g));
            ce_lo_n[g] = !(lo_req && hit);
            ce_hi_n[g] = !(hi_req && hit);
        end
    end

endmodule

// File: rtl/pcm_lane_decode.sv
module pcm_lane_decode
    import pcm_pkg::*;
(
    input  logic   ce1_n,
    input  logic   ce2_n,
    input  logic   reg_n,
    input  logic   a0,
    input  logic   in_range,
    output route_t route
);

    logic word_acc;
    logic low_only;
    logic high_only;

    always_comb begin
        word_acc  = !ce1_n && !ce2_n;
        low_only  = !ce1_n &&  ce2_n;
        high_only =  ce1_n && !ce2_n;
        route     = ROUTE_NONE;
        if (!reg_n) begin
            // attribute space: even bytes only, on the low lane
            if (word_acc || (low_only && !a0)) begin
                route.attr    = 1'b1;
                route.lane_lo = 1'b1;
            end
        end else if (in_range) begin
            if (word_acc) begin
                route.lo_dev  = 1'b1;
                route.hi_dev  = 1'b1;
                route.lane_lo = 1'b1;
                route.lane_hi = 1'b1;
            end else if (low_only) begin
                if (a0) begin
                    route.hi_dev    = 1'b1;
                    route.lane_swap = 1'b1;
                end else begin
                    route.lo_dev  = 1'b1;
                    route.lane_lo = 1'b1;
                end
            end else if (high_only) begin
                route.hi_dev  = 1'b1;
                route.lane_hi = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pcm_xcvr_ctl.sv
module pcm_xcvr_ctl
    import pcm_pkg::*;
(
    input  route_t route,
    input  logic   oe_n,
    input  logic   we_n,
    output logic   lo_en_n,
    output logic   hi_en_n,
    output logic   swap_en_n,
    output logic   to_host
);

    logic one_strobe;
    logic any_lane;

    always_comb begin
        one_strobe = oe_n ^ we_n;
        any_lane   = route.lane_lo || route.lane_hi || route.lane_swap;
        lo_en_n    = !(route.lane_lo   && one_strobe);
        hi_en_n    = !(route.lane_hi   && one_strobe);
        swap_en_n  = !(route.lane_swap && one_strobe);
        to_host    = !oe_n && we_n && any_lane;
    end

endmodule

// File: rtl/pcm_card_ctrl.sv
module pcm_card_ctrl
    import pcm_pkg::*;
#(
    parameter int SEG_COUNT = 10,
    parameter int HADDR_W   = 24,
    parameter int DEV_AW    = 19,
    parameter int ATTR_AW   = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [HADDR_W-1:0]   host_addr,
    input  logic                 ce1_n,
    input  logic                 ce2_n,
    input  logic                 reg_n,
    input  logic                 oe_n,
    input  logic                 we_n,
    input  logic                 wp_sw,
    output logic [SEG_COUNT-1:0] flash_ce_lo_n,
    output logic [SEG_COUNT-1:0] flash_ce_hi_n,
    output logic                 attr_ce_n,
    output logic [DEV_AW-1:0]    dev_addr,
    output logic [ATTR_AW-1:0]   attr_addr,
    output logic                 mem_oe_n,
    output logic                 mem_we_n,
    output logic                 xcv_lo_en_n,
    output logic                 xcv_hi_en_n,
    output logic                 xcv_swap_en_n,
    output logic                 xcv_to_host,
    output logic                 wp_stat
);

    localparam int IDX_LSB = DEV_AW + 1;
    localparam int IDX_W   = HADDR_W - IDX_LSB;

    typedef struct packed {
        logic [SEG_COUNT-1:0] ce_lo_n;
        logic [SEG_COUNT-1:0] ce_hi_n;
        logic                 attr_ce_n;
        logic [DEV_AW-1:0]    dev_addr;
        logic [ATTR_AW-1:0]   attr_addr;
        route_t               route;
        logic                 we_low;
        logic                 oe_n;
        logic                 we_n;
        logic                 x_lo_n;
        logic                 x_hi_n;
        logic                 x_sw_n;
        logic                 to_host;
        logic                 wp;
    } state_t;

    localparam state_t STATE_RST = '{
        ce_lo_n:   '1,
        ce_hi_n:   '1,
        attr_ce_n: 1'b1,
        dev_addr:  '0,
        attr_addr: '0,
        route:     ROUTE_NONE,
        we_low:    1'b0,
        oe_n:      1'b1,
        we_n:      1'b1,
        x_lo_n:    1'b1,
        x_hi_n:    1'b1,
        x_sw_n:    1'b1,
        to_host:   1'b0,
        wp:        1'b0
    };

    state_t state_d, state_q;

    logic                 card_sel;
    logic                 in_range;
    logic                 hold;
    route_t               route_raw;
    route_t               route_new;
    route_t               route_use;
    logic [SEG_COUNT-1:0] seg_lo_n;
    logic [SEG_COUNT-1:0] seg_hi_n;
    logic                 x_lo_n, x_hi_n, x_sw_n, x_to_host;

    always_comb begin
        card_sel  = !ce1_n || !ce2_n;
        route_new = card_sel ? route_raw : ROUTE_NONE;
        hold      = !we_n && state_q.we_low;
        route_use = hold ? state_q.route : route_new;
    end

    pcm_seg_decode #(
        .SEG_COUNT (SEG_COUNT),
        .IDX_W     (IDX_W)
    ) u_seg (
        .seg_idx  (host_addr[HADDR_W-1:IDX_LSB]),
        .lo_req   (route_new.lo_dev),
        .hi_req   (route_new.hi_dev),
        .in_range (in_range),
        .ce_lo_n  (seg_lo_n),
        .ce_hi_n  (seg_hi_n)
    );

    pcm_lane_decode u_lane (
        .ce1_n    (ce1_n),
        .ce2_n    (ce2_n),
        .reg_n    (reg_n),
        .a0       (host_addr[0]),
        .in_range (in_range),
        .route    (route_raw)
    );

    pcm_xcvr_ctl u_xcvr (
        .route     (route_use),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .lo_en_n   (x_lo_n),
        .hi_en_n   (x_hi_n),
        .swap_en_n (x_sw_n),
        .to_host   (x_to_host)
    );

    always_comb begin
        state_d         = state_q;
        state_d.we_low  = !we_n;
        state_d.oe_n    = oe_n;
        state_d.we_n    = we_n || wp_sw;
        state_d.wp      = wp_sw;
        state_d.x_lo_n  = x_lo_n;
        state_d.x_hi_n  = x_hi_n;
        state_d.x_sw_n  = x_sw_n;
        state_d.to_host = x_to_host;
        if (!hold) begin
            state_d.ce_lo_n   = seg_lo_n;
            state_d.ce_hi_n   = seg_hi_n;
            state_d.attr_ce_n = !route_new.attr;
            state_d.dev_addr  = host_addr[DEV_AW:1];
            state_d.attr_addr = host_addr[ATTR_AW:1];
            state_d.route     = route_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= STATE_RST;
        else        state_q <= state_d;
    end

    assign flash_ce_lo_n = state_q.ce_lo_n;
    assign flash_ce_hi_n = state_q.ce_hi_n;
    assign attr_ce_n     = state_q.attr_ce_n;
    assign dev_addr      = state_q.dev_addr;
    assign attr_addr     = state_q.attr_addr;
    assign mem_oe_n      = state_q.oe_n;
    assign mem_we_n      = state_q.we_n;
    assign xcv_lo_en_n   = state_q.x_lo_n;
    assign xcv_hi_en_n   = state_q.x_hi_n;
    assign xcv_swap_en_n = state_q.x_sw_n;
    assign xcv_to_host   = state_q.to_host;
    assign wp_stat       = state_q.wp;

    // R2: deselected, no write pulse -> nothing enabled next cycle
    a_r2_idle_no_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (ce1_n && ce2_n && we_n) |=> (&flash_ce_lo_n && &flash_ce_hi_n && attr_ce_n));

    // R3: at most one pair is ever enabled
    a_r3_one_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~flash_ce_lo_n) && $onehot0(~flash_ce_hi_n));

    // R7: attribute access never overlaps a flash enable, never uses high lanes
    a_r7_attr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !attr_ce_n |-> (&flash_ce_lo_n && &flash_ce_hi_n && xcv_hi_en_n && xcv_swap_en_n));

    // R9: protect switch blocks the write strobe
    a_r9_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        wp_sw |=> mem_we_n);

    // R10: both strobes low -> no transceiver drives
    a_r10_no_contend: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && !we_n) |=> (xcv_lo_en_n && xcv_hi_en_n && xcv_swap_en_n && !xcv_to_host));

    // R11: selection frozen inside a write pulse
    a_r11_hold_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && state_q.we_low) |=> ($stable(flash_ce_lo_n) && $stable(flash_ce_hi_n)
                                       && $stable(attr_ce_n) && $stable(dev_addr)));

    // R12: read strobe passes through one cycle late
    a_r12_oe_follow: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> mem_oe_n);

endmodule

// File: tb/pcm_card_ctrl_bench.sv
module pcm_card_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SEGS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] host_addr = '0;
    logic        ce1_n = 1'b1, ce2_n = 1'b1, reg_n = 1'b1;
    logic        oe_n = 1'b1, we_n = 1'b1, wp_sw = 1'b0;

    logic [SEGS-1:0] flash_ce_lo_n, flash_ce_hi_n;
    logic        attr_ce_n, mem_oe_n, mem_we_n;
    logic [18:0] dev_addr;
    logic [8:0]  attr_addr;
    logic        xcv_lo_en_n, xcv_hi_en_n, xcv_swap_en_n, xcv_to_host, wp_stat;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_tag  = "R1";
    bit    done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_card_ctrl u_pcm_card_ctrl (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr),
        .ce1_n(ce1_n), .ce2_n(ce2_n), .reg_n(reg_n),
        .oe_n(oe_n), .we_n(we_n), .wp_sw(wp_sw),
        .flash_ce_lo_n(flash_ce_lo_n), .flash_ce_hi_n(flash_ce_hi_n),
        .attr_ce_n(attr_ce_n), .dev_addr(dev_addr), .attr_addr(attr_addr),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .xcv_lo_en_n(xcv_lo_en_n), .xcv_hi_en_n(xcv_hi_en_n),
        .xcv_swap_en_n(xcv_swap_en_n), .xcv_to_host(xcv_to_host),
        .wp_stat(wp_stat)
    );

    // ---------------- reference model ----------------
    logic [SEGS-1:0] e_lo, e_hi;
    logic        e_attr, e_oe, e_we, e_wp, e_xl, e_xh, e_xs, e_th;
    logic [18:0] e_dev;
    logic [8:0]  e_aad;
    logic        s_rl, s_rh, s_rs, prev_wel;

    always @(posedge clk or negedge rst_n) begin : model
        int idx;
        bit inr, lo, hi, at, rl, rh, rs, hold, ul, uh, us, act;
        if (!rst_n) begin
            e_lo <= '1; e_hi <= '1; e_attr <= 1; e_dev <= 0; e_aad <= 0;
            e_oe <= 1; e_we <= 1; e_wp <= 0; e_xl <= 1; e_xh <= 1; e_xs <= 1;
            e_th <= 0; s_rl <= 0; s_rh <= 0; s_rs <= 0; prev_wel <= 0;
        end else begin
            idx = int'(host_addr[23:20]);
            inr = idx < SEGS;
            lo = 0; hi = 0; at = 0; rl = 0; rh = 0; rs = 0;
            if (!reg_n) begin
                if ((!ce1_n && !ce2_n) || (!ce1_n && ce2_n && !host_addr[0])) begin
                    at = 1; rl = 1;
                end
            end else if (inr) begin
                if (!ce1_n && !ce2_n) begin lo = 1; hi = 1; rl = 1; rh = 1; end
                else if (!ce1_n) begin
                    if (host_addr[0]) begin hi = 1; rs = 1; end
                    else begin lo = 1; rl = 1; end
                end else if (!ce2_n) begin hi = 1; rh = 1; end
            end
            hold = !we_n && prev_wel;
            if (hold) begin ul = s_rl; uh = s_rh; us = s_rs; end
            else begin
                ul = rl; uh = rh; us = rs;
                e_lo   <= lo ? ~(SEGS'(1) << idx) : '1;
                e_hi   <= hi ? ~(SEGS'(1) << idx) : '1;
                e_attr <= !at;
                e_dev  <= host_addr[19:1];
                e_aad  <= host_addr[9:1];
                s_rl <= rl; s_rh <= rh; s_rs <= rs;
            end
            act = (oe_n != we_n);
            e_xl <= !(ul && act);
            e_xh <= !(uh && act);
            e_xs <= !(us && act);
            e_th <= !oe_n && we_n && (ul || uh || us);
            e_oe <= oe_n;
            e_we <= we_n || wp_sw;
            e_wp <= wp_sw;
            prev_wel <= !we_n;
        end
    end

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", cur_tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("flash_ce_lo R3", 64'(flash_ce_lo_n), 64'(e_lo));
            chk("flash_ce_hi R4", 64'(flash_ce_hi_n), 64'(e_hi));
            chk("attr_ce R7", 64'(attr_ce_n), 64'(e_attr));
            chk("addresses R11", {dev_addr, attr_addr}, {e_dev, e_aad});
            chk("strobes R12 R9", {mem_oe_n, mem_we_n, wp_stat}, {e_oe, e_we, e_wp});
            chk("xcvr R10", {xcv_lo_en_n, xcv_hi_en_n, xcv_swap_en_n, xcv_to_host},
                {e_xl, e_xh, e_xs, e_th});
        end
    end

    task automatic drv(input logic [23:0] a, input logic c1, input logic c2,
                       input logic rg, input logic oe, input logic we,
                       input logic wp, input int n);
        @(negedge clk); #1;
        host_addr = a; ce1_n = c1; ce2_n = c2; reg_n = rg;
        oe_n = oe; we_n = we; wp_sw = wp;
        repeat (n - 1) @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        cur_tag = "R1";
        chk("reset ce", {64'({flash_ce_lo_n, flash_ce_hi_n, attr_ce_n})}, {64'({2*SEGS+1{1'b1}})});
        chk("reset strobes/xcvr",
            {mem_oe_n, mem_we_n, xcv_lo_en_n, xcv_hi_en_n, xcv_swap_en_n, xcv_to_host, wp_stat},
            7'b1111100);
        #1 rst_n = 1'b1;

        cur_tag = "R2";  drv(24'h312345, 1, 1, 1, 0, 1, 0, 3);
        cur_tag = "R3";  drv(24'h000010, 0, 0, 1, 0, 1, 0, 2);
                         drv(24'h3ABCDE, 0, 0, 1, 0, 1, 0, 2);
                         drv(24'h9FFFFE, 0, 0, 1, 0, 1, 0, 2);
        // direct check: pair 9 word read
        @(negedge clk);
        chk("pair9 lo/hi R3", {flash_ce_lo_n, flash_ce_hi_n}, {~(SEGS'(1) << 9), ~(SEGS'(1) << 9)});
        cur_tag = "R4";  drv(24'h200100, 0, 1, 1, 0, 1, 0, 2);
                         drv(24'h200101, 0, 1, 1, 0, 1, 0, 2);
        @(negedge clk);
        chk("odd byte via crossover R4", {xcv_lo_en_n, xcv_swap_en_n, xcv_to_host}, 3'b101);
        cur_tag = "R5";  drv(24'h500101, 1, 0, 1, 0, 1, 0, 3);
        cur_tag = "R6";  drv(24'hA00000, 0, 0, 1, 0, 1, 0, 2);
                         drv(24'hF12345, 0, 1, 1, 0, 1, 0, 2);
        @(negedge clk);
        chk("beyond pairs R6", {64'({flash_ce_lo_n, flash_ce_hi_n, xcv_lo_en_n})}, {64'({2*SEGS+1{1'b1}})});
        cur_tag = "R7";  drv(24'h0001F4, 0, 1, 0, 0, 1, 0, 2);
                         drv(24'h0003FE, 0, 0, 0, 0, 1, 0, 2);
        cur_tag = "R8";  drv(24'h0001F5, 0, 1, 0, 0, 1, 0, 2);
                         drv(24'h0001F5, 1, 0, 0, 0, 1, 0, 2);
        @(negedge clk);
        chk("odd attr R8", {attr_ce_n, xcv_lo_en_n, xcv_hi_en_n}, 3'b111);
        cur_tag = "R11"; drv(24'h100040, 0, 0, 1, 1, 1, 0, 1);
                         drv(24'h100040, 0, 0, 1, 1, 0, 0, 2);
                         drv(24'h400088, 0, 1, 1, 1, 0, 0, 2);
                         drv(24'h400088, 0, 1, 1, 1, 1, 0, 2);
        cur_tag = "R9";  drv(24'h200000, 0, 0, 1, 1, 0, 1, 3);
        @(negedge clk);
        chk("we blocked R9", {mem_we_n, wp_stat}, 2'b11);
        cur_tag = "R10"; drv(24'h200000, 0, 0, 1, 0, 0, 0, 3);
                         drv(24'h200000, 0, 0, 1, 1, 1, 0, 2);
        cur_tag = "R12"; drv(24'h000000, 1, 1, 1, 0, 1, 0, 2);

        cur_tag = "R3 random";
        lfsr = 32'h1ACE_B00C;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            drv(lfsr[23:0], lfsr[24], lfsr[25], lfsr[26] | lfsr[27],
                lfsr[28], lfsr[29] | lfsr[30], lfsr[31] & lfsr[2], 1 + int'(lfsr[3]));
        end
        drv(24'h0, 1, 1, 1, 1, 1, 0, 3);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule